// File: doc/BRIEF.md
# Quad Double-Buffered Converter Code Latch

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host writes codes over a parallel data bus into one of four staging (input) registers, chosen by a 2-bit channel address. The host can use the full 12-bit bus, or an 8-bit bus in two writes: a high byte first, then a low nibble carried on the top four data lines. A separate transfer operation copies all four staging registers at once into four output registers, and those registers drive the converter codes. All four channels therefore change together, even though they were loaded one at a time.

All strobes are active low. They are sampled on the rising edge of a system clock, and every register is a synchronous flop with an asynchronous active-low reset. Staging writes are gated by chip select together with the first write strobe. Transfers are gated only by the transfer strobe together with the second write strobe, so the two paths stay independent of each other.

Top module: `qdac_latch_if`

## Requirements
- R1: While `rst_n` is low, every staging register and every output register is zero, so `dac_code_o` reads all zeros.
- R2: A staging register changes only on a clock edge where `cs_n` and `wr1_n` are both 0. If either one is 1, no staging register changes.
- R3: `ch_sel_i` value k (0 to 3) selects channel k. On a write, only that channel's staging register changes.
- R4: With `full_bus_i` = 1, a write loads all 12 bits `data_i[11:0]` into the selected staging register.
- R5: With `full_bus_i` = 0, a write keeps the upper 8 bits of the selected staging register and loads its lower 4 bits from `data_i[11:8]`.
- R6: On a clock edge where `xfer_n` and `wr2_n` are both 0, all four output registers copy their staging registers. The new codes appear the cycle after that edge. Channel k occupies `dac_code_o[12*k+11 : 12*k]`.
- R7: On a clock edge without a transfer, `dac_code_o` does not change, whatever the staging writes do.
- R8: When a staging write and a transfer happen on the same edge, the output registers take the staging contents as they were before that write.
- R9: An 8-bit host sequence produces the code {B, N}. The sequence is a write with `full_bus_i` = 1 and byte B on `data_i[11:4]`, followed by a write with `full_bus_i` = 0 and nibble N on `data_i[11:8]`.
- R10: A transfer does not depend on `cs_n` or `wr1_n`, and a staging write does not depend on `xfer_n` or `wr2_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 12 | Parallel data bus |
| ch_sel_i | input | 2 | Channel address, bit 1 most significant |
| cs_n | input | 1 | Chip select, active low |
| wr1_n | input | 1 | Staging write strobe, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| wr2_n | input | 1 | Second write strobe, qualifies the transfer, active low |
| full_bus_i | input | 1 | 1: 12-bit write; 0: lower-nibble write from data_i[11:8] |
| dac_code_o | output | 48 | Four converter codes, channel k at bits 12k+11..12k |

## Verification
The checker watches the staging and output registers on every cycle. It verifies that the outputs hold between transfers, that a transfer copies exactly the previous staging contents, that a staging write touches only the addressed channel, and that the 12-bit and nibble write modes fill the right fields. Some behaviours only show up at the ports after a later transfer: the two-write 8-bit sequence, writes ignored while `cs_n` is high, and a write that coincides with a transfer. The bench's directed and random scenarios cover these against its own reference model.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   typedef enum logic {
      BUSW_NIBBLE = 1'b0,
      BUSW_FULL   = 1'b1
   } busw_e;

   typedef struct packed {
      logic load;
      logic xfer;
   } strobe_t;

   function automatic strobe_t decode_strobes(input logic cs_n, input logic wr1_n,
                                              input logic xfer_n, input logic wr2_n);
      strobe_t s;
      s.load = ~cs_n & ~wr1_n;
      s.xfer = ~xfer_n & ~wr2_n;
      return s;
   endfunction

endpackage

// File: rtl/qdac_addr_dec.sv
module qdac_addr_dec #(
   parameter int NCH = 4,
   localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [AW-1:0]  addr_i,
   input  logic           en_i,
   output logic [NCH-1:0] sel_o
);

   for (genvar k = 0; k < NCH; k++) begin : g_sel
      assign sel_o[k] = en_i && (addr_i == AW'(k));
   end

endmodule

// File: rtl/qdac_in_reg.sv
module qdac_in_reg #(
   parameter int DW  = 12,
   parameter int HIW = 8,
   localparam int LOW = DW - HIW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic          full_i,
   input  logic [DW-1:0] bus_i,
   output logic [DW-1:0] q_o
);

   logic [HIW-1:0] hi_q;
   logic [LOW-1:0] lo_q;
   logic [LOW-1:0] lo_src;
   logic           hi_we;

   if (LOW > HIW) begin : g_bad_split
      $error("qdac_in_reg: lower section wider than upper section");
   end

   // lower section source: own lines in full mode, top lines in nibble mode
   assign lo_src = full_i ? bus_i[LOW-1:0] : bus_i[DW-1 -: LOW];
   assign hi_we  = we_i & full_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
      end else if (hi_we) begin
         hi_q <= bus_i[DW-1 -: HIW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else if (we_i) begin
         lo_q <= lo_src;
      end
   end

   assign q_o = {hi_q, lo_q};

endmodule

// File: rtl/qdac_out_reg.sv
module qdac_out_reg #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          xfer_i,
   input  logic [DW-1:0] d_i,
   output logic [DW-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (xfer_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/qdac_latch_if.sv
module qdac_latch_if #(
   parameter int NCH = 4,
   parameter int DW  = 12,
   parameter int HIW = 8,
   localparam int AW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int OW = NCH * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] data_i,
   input  logic [AW-1:0] ch_sel_i,
   input  logic          cs_n,
   input  logic          wr1_n,
   input  logic          xfer_n,
   input  logic          wr2_n,
   input  logic          full_bus_i,
   output logic [OW-1:0] dac_code_o
);
   import qdac_pkg::*;

   if (NCH < 1 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("qdac_latch_if: channel count must be a power of two");
   end
   if (HIW < 1 || HIW >= DW) begin : g_bad_hiw
      $error("qdac_latch_if: upper section must be narrower than the code");
   end

   strobe_t        stb;
   logic [NCH-1:0] ch_we;
   logic [OW-1:0]  in_flat;
   busw_e          busw;

   assign stb  = decode_strobes(cs_n, wr1_n, xfer_n, wr2_n);
   assign busw = busw_e'(full_bus_i);

   qdac_addr_dec #(.NCH(NCH)) u_dec (
      .addr_i (ch_sel_i),
      .en_i   (stb.load),
      .sel_o  (ch_we)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      qdac_in_reg #(.DW(DW), .HIW(HIW)) u_in (
         .clk    (clk),
         .rst_n  (rst_n),
         .we_i   (ch_we[k]),
         .full_i (busw == BUSW_FULL),
         .bus_i  (data_i),
         .q_o    (in_flat[k*DW +: DW])
      );

      qdac_out_reg #(.DW(DW)) u_out (
         .clk    (clk),
         .rst_n  (rst_n),
         .xfer_i (stb.xfer),
         .d_i    (in_flat[k*DW +: DW]),
         .q_o    (dac_code_o[k*DW +: DW])
      );
   end

endmodule

// File: rtl/qdac_latch_if_chk.sv
module qdac_latch_if_chk #(
   parameter int NCH = 4,
   parameter int DW  = 12,
   parameter int HIW = 8,
   localparam int AW  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int OW  = NCH * DW,
   localparam int LOW = DW - HIW
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] data_i,
   input logic [AW-1:0] ch_sel_i,
   input logic          cs_n,
   input logic          wr1_n,
   input logic          xfer_n,
   input logic          wr2_n,
   input logic          full_bus_i,
   input logic [OW-1:0] in_flat,
   input logic [OW-1:0] dac_code_o
);

   logic load_c, xfer_c;
   assign load_c = !cs_n && !wr1_n;
   assign xfer_c = !xfer_n && !wr2_n;

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_zero: assert (dac_code_o == '0 && in_flat == '0)
            else $error("R1: registers not clear during reset");
      end
   end

   a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      !load_c |=> $stable(in_flat));

   a_r6_xfer_copies: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_c |=> dac_code_o == $past(in_flat));

   a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_c |=> $stable(dac_code_o));

   a_r8_pre_write_value: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_c && load_c) |=> dac_code_o == $past(in_flat));

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      a_r3_other_ch_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (load_c && ch_sel_i != AW'(k)) |=> $stable(in_flat[k*DW +: DW]));

      a_r4_full_load: assert property (@(posedge clk) disable iff (!rst_n)
         (load_c && ch_sel_i == AW'(k) && full_bus_i)
         |=> in_flat[k*DW +: DW] == $past(data_i));

      a_r5_nibble_load: assert property (@(posedge clk) disable iff (!rst_n)
         (load_c && ch_sel_i == AW'(k) && !full_bus_i)
         |=> (in_flat[k*DW+LOW +: HIW] == $past(in_flat[k*DW+LOW +: HIW]))
          && (in_flat[k*DW +: LOW] == $past(data_i[DW-1 -: LOW])));
   end

endmodule

bind qdac_latch_if qdac_latch_if_chk #(.NCH(NCH), .DW(DW), .HIW(HIW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .data_i     (data_i),
   .ch_sel_i   (ch_sel_i),
   .cs_n       (cs_n),
   .wr1_n      (wr1_n),
   .xfer_n     (xfer_n),
   .wr2_n      (wr2_n),
   .full_bus_i (full_bus_i),
   .in_flat    (in_flat),
   .dac_code_o (dac_code_o)
);

// File: tb/qdac_latch_if_bench.sv
`timescale 1ns/1ps
module qdac_latch_if_bench;

   localparam int NCH = 4;
   localparam int DW  = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [DW-1:0]   data_i = '0;
   logic [1:0]      ch_sel_i = '0;
   logic            cs_n = 1'b1, wr1_n = 1'b1, xfer_n = 1'b1, wr2_n = 1'b1;
   logic            full_bus_i = 1'b1;
   logic [NCH*DW-1:0] dac_code_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [DW-1:0] in_m  [NCH];
   logic [DW-1:0] dac_m [NCH];

   always #2 clk = ~clk;

   qdac_latch_if u_qdac_latch_if (
      .clk(clk), .rst_n(rst_n), .data_i(data_i), .ch_sel_i(ch_sel_i),
      .cs_n(cs_n), .wr1_n(wr1_n), .xfer_n(xfer_n), .wr2_n(wr2_n),
      .full_bus_i(full_bus_i), .dac_code_o(dac_code_o)
   );

   function automatic logic [DW-1:0] next_in(logic [DW-1:0] old, logic full, logic [DW-1:0] bus);
      return full ? bus : {old[DW-1:4], bus[DW-1 -: 4]};
   endfunction

   task automatic check_all(string tag);
      for (int k = 0; k < NCH; k++) begin
         checks++;
         if (dac_code_o[k*DW +: DW] !== dac_m[k]) begin
            errors++;
            $display("FAIL %s ch%0d actual %h expected %h", tag, k,
                     dac_code_o[k*DW +: DW], dac_m[k]);
         end
      end
   endtask

   // one bus cycle: drive at negedge, hold over one rising edge, then idle and check
   task automatic op(logic c, logic w1, logic x, logic w2, logic full,
                     logic [1:0] ch, logic [DW-1:0] d, string tag);
      logic ld, xf;
      @(negedge clk);
      cs_n = c; wr1_n = w1; xfer_n = x; wr2_n = w2;
      full_bus_i = full; ch_sel_i = ch; data_i = d;
      @(posedge clk);
      #1;
      cs_n = 1'b1; wr1_n = 1'b1; xfer_n = 1'b1; wr2_n = 1'b1;
      ld = !c && !w1;
      xf = !x && !w2;
      if (xf) for (int k = 0; k < NCH; k++) dac_m[k] = in_m[k];
      if (ld) in_m[ch] = next_in(in_m[ch], full, d);
      check_all(tag);
   endtask

   task automatic wr(logic full, logic [1:0] ch, logic [DW-1:0] d, string tag);
      op(1'b0, 1'b0, 1'b1, 1'b1, full, ch, d, tag);
   endtask

   task automatic xfer(string tag);
      op(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, '0, tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0A17));
      for (int k = 0; k < NCH; k++) begin in_m[k] = '0; dac_m[k] = '0; end
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R4 / R3: full write to channel 2 only
      wr(1'b1, 2'd2, 12'hABC, "R7 no xfer");
      xfer("R4 R3 full write ch2");

      // R2: gated writes leave staging untouched
      op(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 12'h111, "R2 cs high");
      op(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 12'h222, "R2 wr1 high");
      xfer("R2 staging kept");

      // R9: 8-bit host sequence on channel 1
      wr(1'b1, 2'd1, 12'h5A7, "R7 hold");
      wr(1'b0, 2'd1, 12'hC00, "R7 hold");
      xfer("R9 byte then nibble");

      // R5: nibble-only write keeps upper byte
      wr(1'b0, 2'd2, 12'h3FF, "R7 hold");
      xfer("R5 nibble write ch2");

      // R8: write and transfer on the same edge
      op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 12'h123, "R8 pre-write value");
      xfer("R8 write lands next xfer");

      // R7: only one transfer strobe, no transfer
      wr(1'b1, 2'd3, 12'hFED, "R7");
      op(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, '0, "R7 xfer only");
      op(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, '0, "R7 wr2 only");
      // R10: transfer while chip select inactive
      xfer("R10 xfer with cs high");

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic c, w1, x, w2;
         c  = ($urandom % 4) == 0;
         w1 = ($urandom % 3) == 0;
         x  = ($urandom % 3) != 0;
         w2 = ($urandom % 4) == 0;
         op(c, w1, x, w2, 1'($urandom), 2'($urandom), 12'($urandom),
            "R6 R3 R4 R5 R10 random");
      end

      // R1: reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      for (int k = 0; k < NCH; k++) begin in_m[k] = '0; dac_m[k] = '0; end
      check_all("R1 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      xfer("R1 staging cleared");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule